// File: doc/BRIEF.md
# Stipple and Blit Pixel Write Engine

This block accelerates pixel writes into an 8-bit framebuffer that is arranged with a fixed 1024-byte line pitch. A host reaches it through two write windows: a stipple window and a blit window. In either window, a 32-bit write with address bit 2 clear only loads a colour latch. A write with address bit 2 set starts a command. Its destination pixel index comes from the address: `bus_addr[22:3]`, which is (address >> 3) masked to 20 bits.

In the stipple window, the write data is a 32-bit mask. Bit 31 controls destination+0 and bit 0 controls destination+31. Every set bit stores the latched colour byte at its pixel. Pixels whose bit is clear keep their contents. In the blit window, the data word carries two fields: a 24-bit source pixel index in bits [23:0] and a run length minus one in bits [28:24]. Bits [31:29] are ignored. A source of all ones fills the run with the colour byte. Any other source copies the run from the source, moving upward from the lowest address. Because of that order, a forward overlap (destination one above the source) smears the first source byte across the whole run.

The engine drives a single-port byte memory whose read data arrives one clock after the read strobe. It writes one pixel per clock. A copy costs a read clock and then a write clock per pixel. `busy` is high from the clock after a command is accepted until the clock after the dirty pulse. Any bus write presented while busy is dropped, so the host must wait for `busy` to fall before writing again.

The state machine has these states:
- `ST_IDLE`: waits for a command.
- `ST_STIPPLE`: walks 32 mask bits.
- `ST_FILL`: writes the run.
- `ST_COPY_RD`: reads source+i.
- `ST_COPY_WR`: writes destination+i.
- `ST_DONE`: emits the dirty pulse.

The transitions are:
- `ST_IDLE` to `ST_STIPPLE`, `ST_FILL` or `ST_COPY_RD` when a command is accepted. The target depends on the window and the source field.
- `ST_STIPPLE` and `ST_FILL` loop on themselves until the last index, then go to `ST_DONE`.
- `ST_COPY_RD` always goes to `ST_COPY_WR`.
- `ST_COPY_WR` goes back to `ST_COPY_RD` until the last index, then to `ST_DONE`.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `stipblit_engine`

## Requirements
- R1: An accepted write with address bit 2 clear stores bits [7:0] of the data as the colour byte. It causes no memory access and leaves `busy` low. After reset the colour byte is 0x00.
- R2: An accepted write with address bit 2 set starts a command whose destination pixel index is `bus_addr[22:3]`.
- R3: Stipple (`bus_win`=0) visits destination+0 through destination+31 in order. Mask bit 31-i decides whether pixel destination+i gets the colour byte. A clear bit leaves its pixel unchanged. `busy` lasts 33 clocks.
- R4: Blit (`bus_win`=1) uses length = data[28:24]+1, giving 1 to 32 pixels. Data bits [31:29] are ignored.
- R5: A blit whose data[23:0] is 0xFFFFFF fills the run with the colour byte. `busy` lasts length+1 clocks.
- R6: A blit with any other source copies byte source+i to destination+i for i ascending, with each read completing before its write. `busy` lasts 2*length+1 clocks, and forward overlap propagates the first byte.
- R7: `bus_rdata` is 0 for every read, at all times.
- R8: A write is accepted only with all four byte enables set and `bus_addr[1:0]`=0. Any other write changes neither the colour byte nor memory.
- R9: Writes presented while `busy` is high are ignored entirely. `busy` stays high until the dirty pulse.
- R10: At completion, `dirty_valid` is high for exactly one clock. It carries the destination index on `dirty_start` and the pixel count on `dirty_len` (32 for stipple), and `busy` falls on the next clock.
- R11: The memory port never reads and writes in the same clock. Every copy read is followed by a write in the next clock.
- R12: After reset `busy`, `dirty_valid`, `mem_we` and `mem_re` are low. No memory access occurs while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_win | input | 1 | Window select: 0 stipple, 1 blit |
| bus_addr | input | 23 | Byte offset within the window |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| busy | output | 1 | Command in progress; writes are dropped |
| mem_addr | output | 24 | Pixel index for the framebuffer memory |
| mem_we | output | 1 | Memory byte write strobe |
| mem_re | output | 1 | Memory byte read strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid one clock after `mem_re` |
| dirty_valid | output | 1 | One-clock completion pulse |
| dirty_start | output | 20 | First modified pixel index |
| dirty_len | output | 6 | Number of pixels covered |

## Verification
The hardest situation to reach from the ports is a write that arrives while a command is still running. Driving one at the wrong moment simply lands after `busy` falls. The stimulus therefore starts a 33-clock stipple and, in the very next clocks, issues both a new colour and a fill command. It then proves both were dropped: the fill's target stays untouched, and a later colour-less fill still uses the old colour. Overlapping copies in both directions are run against a bench model that applies the ascending order, so a reversed or batched copy shows up as a byte mismatch.

// File: rtl/stipblit_pkg.sv
package stipblit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STIPPLE,
        ST_FILL,
        ST_COPY_RD,
        ST_COPY_WR,
        ST_DONE
    } sb_state_e;

    typedef enum logic [1:0] {
        OP_STIPPLE,
        OP_FILL,
        OP_COPY
    } sb_op_e;

endpackage

// File: rtl/sb_cmd_decode.sv
module sb_cmd_decode
    import stipblit_pkg::*;
#(
    parameter int DST_W  = 20,
    parameter int SRC_W  = 24,
    parameter int RUN_W  = 5,
    parameter int PIX_W  = 8,
    parameter int DATA_W = 32,
    localparam int BUS_AW = DST_W + 3,
    localparam int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_win,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              busy,
    output logic [PIX_W-1:0]  colour_q,
    output logic              start,
    output sb_op_e            start_op,
    output logic [DST_W-1:0]  start_dst,
    output logic [SRC_W-1:0]  start_src,
    output logic [RUN_W-1:0]  start_last,
    output logic [DATA_W-1:0] start_mask
);

    logic accept;
    logic unused_hi;

    // Only aligned full-word writes outside a running command count.
    assign accept = bus_wr && !busy && (&bus_be) && (bus_addr[1:0] == 2'b00);
    assign start  = accept && bus_addr[2];

    assign start_dst  = bus_addr[BUS_AW-1:3];
    assign start_src  = bus_wdata[SRC_W-1:0];
    assign start_mask = bus_wdata;
    assign unused_hi  = ^bus_wdata[DATA_W-1:SRC_W+RUN_W];

    always_comb begin
        if (!bus_win) begin
            start_op   = OP_STIPPLE;
            start_last = '1;
        end else begin
            start_op   = (&bus_wdata[SRC_W-1:0]) ? OP_FILL : OP_COPY;
            start_last = bus_wdata[SRC_W +: RUN_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            colour_q <= '0;
        end else if (accept && !bus_addr[2]) begin
            colour_q <= bus_wdata[PIX_W-1:0];
        end
    end

    // R1: a command write never disturbs the colour latch
    a_r1_cmd_keeps_colour: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> $stable(colour_q));

    // R9: nothing is latched while a command runs
    a_r9_busy_blocks_latch: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(colour_q));

endmodule

// File: rtl/sb_sequencer.sv
module sb_sequencer
    import stipblit_pkg::*;
#(
    parameter int DST_W  = 20,
    parameter int SRC_W  = 24,
    parameter int RUN_W  = 5,
    parameter int PIX_W  = 8,
    parameter int DATA_W = 32,
    localparam int LEN_W = RUN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  sb_op_e            start_op,
    input  logic [DST_W-1:0]  start_dst,
    input  logic [SRC_W-1:0]  start_src,
    input  logic [RUN_W-1:0]  start_last,
    input  logic [DATA_W-1:0] start_mask,
    input  logic [PIX_W-1:0]  colour,
    input  logic [PIX_W-1:0]  mem_rdata,
    output logic [SRC_W-1:0]  mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [PIX_W-1:0]  mem_wdata,
    output logic              busy,
    output logic              dirty_valid,
    output logic [DST_W-1:0]  dirty_start,
    output logic [LEN_W-1:0]  dirty_len
);

    sb_state_e            state_q, state_nx;
    sb_op_e               op_q;
    logic [DST_W-1:0]     dst_q;
    logic [SRC_W-1:0]     src_q;
    logic [RUN_W-1:0]     last_q;
    logic [RUN_W-1:0]     idx_q;
    logic [DATA_W-1:0]    mask_q;
    logic                 at_last;
    logic [SRC_W-1:0]     dst_ptr;
    logic [SRC_W-1:0]     src_ptr;

    assign at_last = (idx_q == last_q);
    assign dst_ptr = SRC_W'(dst_q) + SRC_W'(idx_q);
    assign src_ptr = src_q + SRC_W'(idx_q);

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    unique case (start_op)
                        OP_STIPPLE: state_nx = ST_STIPPLE;
                        OP_FILL:    state_nx = ST_FILL;
                        default:    state_nx = ST_COPY_RD;
                    endcase
                end
            end
            ST_STIPPLE: if (at_last) state_nx = ST_DONE;
            ST_FILL:    if (at_last) state_nx = ST_DONE;
            ST_COPY_RD: state_nx = ST_COPY_WR;
            ST_COPY_WR: state_nx = at_last ? ST_DONE : ST_COPY_RD;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // command registers, index counter and mask shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_STIPPLE;
            dst_q  <= '0;
            src_q  <= '0;
            last_q <= '0;
            idx_q  <= '0;
            mask_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                op_q   <= start_op;
                dst_q  <= start_dst;
                src_q  <= start_src;
                last_q <= start_last;
                idx_q  <= '0;
                mask_q <= start_mask;
            end
            if (state_q == ST_STIPPLE || state_q == ST_FILL || state_q == ST_COPY_WR) begin
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == ST_STIPPLE) begin
                mask_q <= mask_q << 1;
            end
        end
    end

    // outputs
    always_comb begin
        mem_addr    = '0;
        mem_we      = 1'b0;
        mem_re      = 1'b0;
        mem_wdata   = colour;
        dirty_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_STIPPLE: begin
                mem_addr = dst_ptr;
                mem_we   = mask_q[DATA_W-1];
            end
            ST_FILL: begin
                mem_addr = dst_ptr;
                mem_we   = 1'b1;
            end
            ST_COPY_RD: begin
                mem_addr = src_ptr;
                mem_re   = 1'b1;
            end
            ST_COPY_WR: begin
                mem_addr  = dst_ptr;
                mem_we    = 1'b1;
                mem_wdata = mem_rdata;
            end
            ST_DONE: dirty_valid = 1'b1;
            default: ;
        endcase
    end

    assign busy        = (state_q != ST_IDLE);
    assign dirty_start = dst_q;
    assign dirty_len   = LEN_W'(last_q) + 1'b1;

    // R11: single-port memory, never both strobes
    a_r11_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R11: a copy read is always followed by its write
    a_r11_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> mem_we);

    // R12: memory quiet while idle
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    // R9: busy persists until the completion pulse
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dirty_valid) |=> busy);

    // R10: single-clock pulse, then release
    a_r10_pulse_release: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_valid |=> (!dirty_valid && !busy));

    // R3: stipple always reports a 32-pixel range
    a_r3_stipple_span: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_valid && op_q == OP_STIPPLE) |-> (dirty_len == LEN_W'(DATA_W)));

    // R4: reported length is never zero
    a_r4_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_valid |-> (dirty_len != '0));

endmodule

// File: rtl/stipblit_engine.sv
module stipblit_engine
    import stipblit_pkg::*;
#(
    parameter int DST_W  = 20,
    parameter int SRC_W  = 24,
    parameter int RUN_W  = 5,
    parameter int PIX_W  = 8,
    parameter int DATA_W = 32,
    localparam int BUS_AW = DST_W + 3,
    localparam int BE_W   = DATA_W / 8,
    localparam int LEN_W  = RUN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_win,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic [SRC_W-1:0]  mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic [PIX_W-1:0]  mem_rdata,
    output logic              dirty_valid,
    output logic [DST_W-1:0]  dirty_start,
    output logic [LEN_W-1:0]  dirty_len
);

    logic              start;
    sb_op_e            start_op;
    logic [DST_W-1:0]  start_dst;
    logic [SRC_W-1:0]  start_src;
    logic [RUN_W-1:0]  start_last;
    logic [DATA_W-1:0] start_mask;
    logic [PIX_W-1:0]  colour_q;
    logic              unused_rd;

    // Engine windows carry no readable state.
    assign bus_rdata = '0;
    assign unused_rd = bus_rd;

    sb_cmd_decode #(
        .DST_W(DST_W), .SRC_W(SRC_W), .RUN_W(RUN_W),
        .PIX_W(PIX_W), .DATA_W(DATA_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_win(bus_win), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .busy(busy),
        .colour_q(colour_q), .start(start), .start_op(start_op),
        .start_dst(start_dst), .start_src(start_src),
        .start_last(start_last), .start_mask(start_mask)
    );

    sb_sequencer #(
        .DST_W(DST_W), .SRC_W(SRC_W), .RUN_W(RUN_W),
        .PIX_W(PIX_W), .DATA_W(DATA_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_op(start_op), .start_dst(start_dst),
        .start_src(start_src), .start_last(start_last),
        .start_mask(start_mask), .colour(colour_q),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .busy(busy),
        .dirty_valid(dirty_valid), .dirty_start(dirty_start),
        .dirty_len(dirty_len)
    );

    // R7: reads always return zero
    a_r7_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_rdata == '0));

endmodule

// File: tb/sim_stipblit_engine.sv
module sim_stipblit_engine;

    localparam int MSZ = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_win = 1'b0;
    logic [22:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        busy;
    logic [23:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        dirty_valid;
    logic [19:0] dirty_start;
    logic [5:0]  dirty_len;

    logic [7:0]  ram   [MSZ];
    logic [7:0]  model [MSZ];
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    stipblit_engine u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_win(bus_win), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dirty_valid(dirty_valid), .dirty_start(dirty_start),
        .dirty_len(dirty_len)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MSZ; i++) ram[i] <= 8'(i * 7 + 3);
            mem_rdata <= '0;
        end else begin
            if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;
            if (mem_re) mem_rdata <= ram[mem_addr[11:0]];
        end
    end

    typedef struct packed {
        logic        blit;
        logic [11:0] dst;
        logic [31:0] colour;
        logic [31:0] data;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b0, 12'd16,   32'h000000A5, 32'hF0F00001},
        '{1'b0, 12'd200,  32'h12345677, 32'h00000000},
        '{1'b0, 12'd300,  32'hFFFFFFFF, 32'hFFFFFFFF},
        '{1'b1, 12'd500,  32'h0000003C, 32'h00FFFFFF},
        '{1'b1, 12'd600,  32'hABCDEFC3, 32'h1FFFFFFF},
        '{1'b1, 12'd1000, 32'h00000011, 32'h09000064},
        '{1'b1, 12'd2001, 32'h00000022, 32'h070007D0},
        '{1'b1, 12'd2999, 32'h00000033, 32'h04000BB8},
        '{1'b1, 12'd3500, 32'h00000044, 32'hE3000028}
    };

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic ref_apply(input logic blit, input int dst,
                             input logic [7:0] col, input logic [31:0] data);
        if (!blit) begin
            for (int i = 0; i < 32; i++)
                if (data[31-i]) model[(dst + i) % MSZ] = col;
        end else begin
            int len = int'(data[28:24]) + 1;
            int src = int'(data[23:0]);
            for (int i = 0; i < len; i++) begin
                if (data[23:0] == 24'hFFFFFF) model[(dst + i) % MSZ] = col;
                else model[(dst + i) % MSZ] = model[(src + i) % MSZ];
            end
        end
    endtask

    task automatic bus_pulse(input logic win, input logic [22:0] addr,
                             input logic [31:0] data, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_win = win; bus_addr = addr;
        bus_wdata = data; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic wait_done(output int cyc, output int npulse,
                             output logic [19:0] ds, output logic [5:0] dl);
        cyc = 0; npulse = 0; ds = '0; dl = '0;
        while (busy && cyc < 1000) begin
            cyc++;
            if (dirty_valid) begin
                npulse++; ds = dirty_start; dl = dirty_len;
            end
            @(negedge clk);
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        for (int i = 0; i < MSZ; i++) begin
            if (ram[i] !== model[i]) begin
                if (bad == 0)
                    $display("  first mismatch at %0d: ram=%0h model=%0h", i, ram[i], model[i]);
                bad++;
            end
        end
        check_eq(req, "memory mismatches", bad, 0);
    endtask

    function automatic logic [22:0] cmd_addr(input int dst);
        return {20'(dst), 3'b100};
    endfunction

    function automatic logic [22:0] col_addr(input int dst);
        return {20'(dst), 3'b000};
    endfunction

    initial begin
        int cyc, np, exp_len, exp_cyc;
        logic [19:0] ds;
        logic [5:0]  dl;
        for (int i = 0; i < MSZ; i++) model[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        check_eq("R12", "busy after reset", busy, 0);
        check_eq("R12", "dirty_valid after reset", dirty_valid, 0);
        check_eq("R12", "mem strobes after reset", {mem_we, mem_re}, 0);

        // R1: colour latch is zero after reset
        bus_pulse(1'b1, cmd_addr(3700), 32'h02FFFFFF, 4'hF);
        ref_apply(1'b1, 3700, 8'h00, 32'h02FFFFFF);
        wait_done(cyc, np, ds, dl);
        cmp_mem("R1");

        // R1: a colour write alone leaves busy low and memory untouched
        bus_pulse(1'b0, col_addr(10), 32'h0000005A, 4'hF);
        check_eq("R1", "busy after colour write", busy, 0);
        cmp_mem("R1");

        // Table walk: R2 R3 R4 R5 R6 R10
        for (int k = 0; k < 9; k++) begin
            vec_t v = VECS[k];
            bus_pulse(v.blit, col_addr(int'(v.dst)), v.colour, 4'hF);
            bus_pulse(v.blit, cmd_addr(int'(v.dst)), v.data, 4'hF);
            ref_apply(v.blit, int'(v.dst), v.colour[7:0], v.data);
            wait_done(cyc, np, ds, dl);
            if (!v.blit) begin
                exp_len = 32; exp_cyc = 33;
            end else begin
                exp_len = int'(v.data[28:24]) + 1;
                exp_cyc = (v.data[23:0] == 24'hFFFFFF) ? exp_len + 1 : 2 * exp_len + 1;
            end
            check_eq("R10", $sformatf("vec%0d pulse count", k), np, 1);
            check_eq("R2", $sformatf("vec%0d dirty_start", k), ds, v.dst);
            check_eq("R4", $sformatf("vec%0d dirty_len", k), dl, exp_len);
            check_eq(v.blit ? ((v.data[23:0] == 24'hFFFFFF) ? "R5" : "R6") : "R3",
                     $sformatf("vec%0d busy cycles", k), cyc, exp_cyc);
            cmp_mem(v.blit ? ((v.data[23:0] == 24'hFFFFFF) ? "R5" : "R6") : "R3");
        end

        // R9: writes during busy are dropped
        bus_pulse(1'b0, col_addr(3800), 32'h00000077, 4'hF);
        bus_pulse(1'b0, cmd_addr(3800), 32'hFFFFFFFF, 4'hF);
        ref_apply(1'b0, 3800, 8'h77, 32'hFFFFFFFF);
        bus_pulse(1'b1, col_addr(3900), 32'h00000099, 4'hF);
        bus_pulse(1'b1, cmd_addr(3900), 32'h03FFFFFF, 4'hF);
        check_eq("R9", "busy still high after dropped writes", busy, 1);
        wait_done(cyc, np, ds, dl);
        check_eq("R9", "dirty_start of running command", ds, 3800);
        cmp_mem("R9");
        bus_pulse(1'b1, cmd_addr(3950), 32'h02FFFFFF, 4'hF);
        ref_apply(1'b1, 3950, 8'h77, 32'h02FFFFFF);
        wait_done(cyc, np, ds, dl);
        cmp_mem("R9");

        // R8: partial byte enables or misaligned addresses are ignored
        bus_pulse(1'b1, col_addr(3960), 32'h00000055, 4'h7);
        bus_pulse(1'b1, col_addr(3960) | 23'd1, 32'h00000056, 4'hF);
        bus_pulse(1'b1, cmd_addr(3960), 32'h01FFFFFF, 4'hF);
        ref_apply(1'b1, 3960, 8'h77, 32'h01FFFFFF);
        wait_done(cyc, np, ds, dl);
        cmp_mem("R8");
        bus_pulse(1'b1, cmd_addr(3970), 32'h01FFFFFF, 4'hE);
        check_eq("R8", "busy after partial command", busy, 0);
        cmp_mem("R8");

        // R7: reads return zero, idle and busy
        @(negedge clk); bus_rd = 1'b1;
        @(negedge clk);
        check_eq("R7", "rdata idle", bus_rdata, 0);
        bus_rd = 1'b0;
        bus_pulse(1'b0, cmd_addr(4000), 32'h80000000, 4'hF);
        ref_apply(1'b0, 4000, 8'h77, 32'h80000000);
        bus_rd = 1'b1;
        @(negedge clk);
        check_eq("R7", "rdata busy", bus_rdata, 0);
        bus_rd = 1'b0;
        wait_done(cyc, np, ds, dl);
        cmp_mem("R3");

        // R11: copy wrapping a long run, then idle quiet
        bus_pulse(1'b1, cmd_addr(1200), 32'h1F000064, 4'hF);
        ref_apply(1'b1, 1200, 8'h77, 32'h1F000064);
        wait_done(cyc, np, ds, dl);
        check_eq("R11", "32-pixel copy cycles", cyc, 65);
        cmp_mem("R6");
        check_eq("R12", "mem strobes idle", {mem_we, mem_re}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule